// File: doc/BRIEF.md
# Audio Port Register Bank with Atomic Bit Aliases

This block is the software-visible register file of a stereo serial audio port. It holds the port's control word, a status word with sticky FIFO event flags, a 32-bit sample word (right channel in the upper half, left channel in the lower half) and a read-only version word. The serial engine and its FIFO sit outside this block. They report events as one-cycle pulses and report their busy, present and DMA-request conditions as levels.

Each register can be written in four ways, chosen by address bits 3:2: a plain write, a bit-set, a bit-clear and a bit-toggle. Driver code can therefore change single control bits without a read-modify-write sequence. The sticky error flags are acknowledged by writing ones through the clear alias. The block combines the flags with their enable bits to drive two interrupt lines, and it gates the engine's DMA request with the run bit.

Top module: `aud_regbank`

## Requirements
- R1: The register bases are 0x00 (control), 0x10 (status), 0x20 (sample data) and 0x30 (version). Address bits 3:2 select the alias: 0 plain, 1 set, 2 clear, 3 toggle. A read at any alias returns the register value in the same cycle. An address with bits 1:0 non-zero, or an address at or above 0x40, reads as zero and its writes are ignored.
- R2: A plain write replaces the writable bits. A set write ORs the write data in, a clear write ANDs in its inverse and a toggle write XORs it in. The new value is visible from the clock edge that takes the write.
- R3: The control register resets to 0x4000_0000 (bit 30 is the clock gate). Bits 23:21 are reserved: they always read as zero and ignore writes.
- R4: Status bit 31 follows `hw_present`, bit 16 follows `hw_dma_req` and bit 0 follows `hw_busy`. All three are live and no write can change them. Status bits 15:7, 30:17 and 3:1 read as zero.
- R5: A pulse on `evt_underflow`, `evt_overflow` or `evt_service` sets status bit 6, 5 or 4 respectively at the next edge. The flag stays set until a clear-alias write to status has a one in that bit. Plain, set and toggle writes to status do not affect any flag.
- R6: When an event pulse and a clear-alias write hit the same flag in the same cycle, the flag stays set.
- R7: `irq_err` is (underflow OR overflow) AND control bit 25. `irq_svc` is the service flag AND control bit 24. `dma_req` is `hw_dma_req` AND control bit 0 (run).
- R8: The version register reads {VER_MAJOR[31:24], VER_MINOR[23:16], VER_STEP[15:0]}, with defaults 0x01, 0x03 and 0x0042 giving 0x0103_0042. Writes at any of its aliases change nothing.
- R9: Control bit 31 is soft reset. From the edge after it reads 1, and for as long as it stays 1, control bits 29:0, the sample word and all flags are held at their defaults (zero), and events and writes to them have no effect. Bits 31 and 30 stay writable, and clearing bit 31 returns the block to normal operation.
- R10: `ctrl_o` and `data_o` always present the current control and sample register values to the serial engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| hw_present | input | 1 | Engine present level |
| hw_busy | input | 1 | Engine busy level |
| hw_dma_req | input | 1 | FIFO DMA request level |
| evt_underflow | input | 1 | FIFO underflow pulse |
| evt_overflow | input | 1 | FIFO overflow pulse |
| evt_service | input | 1 | FIFO service pulse |
| irq_err | output | 1 | FIFO error interrupt |
| irq_svc | output | 1 | FIFO service interrupt |
| dma_req | output | 1 | DMA request gated by run |
| ctrl_o | output | 32 | Current control word |
| data_o | output | 32 | Current sample word |

## Verification
Reads and the level-mirrored status bits are combinational, so they are due in the same cycle as the address or input change. Writes and event pulses land at the next rising edge, and the interrupt lines follow the flags without further delay. Soft reset clears the other state one edge after bit 31 reads 1. The bench therefore drives every input on the falling edge, lets exactly one rising edge pass for a write or pulse (two edges for soft reset), and samples 1 ns after the next falling edge, well before the edge that follows.

// File: rtl/aud_regbank_pkg.sv
package aud_regbank_pkg;

   localparam int unsigned DW = 32;

   typedef enum logic [1:0] {
      OP_WRITE  = 2'd0,
      OP_SET    = 2'd1,
      OP_CLEAR  = 2'd2,
      OP_TOGGLE = 2'd3
   } alias_op_e;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_STAT = 2'd1,
      SEL_DATA = 2'd2,
      SEL_VER  = 2'd3
   } reg_sel_e;

   // control bit positions
   localparam int unsigned CB_SRST   = 31;
   localparam int unsigned CB_GATE   = 30;
   localparam int unsigned CB_ERR_EN = 25;
   localparam int unsigned CB_SVC_EN = 24;
   localparam int unsigned CB_RUN    = 0;

   // status bit positions
   localparam int unsigned SB_PRESENT = 31;
   localparam int unsigned SB_DMA     = 16;
   localparam int unsigned SB_FLAG_LO = 4;   // service=4, overflow=5, underflow=6
   localparam int unsigned SB_BUSY    = 0;

   localparam int unsigned N_FLAGS = 3;
   localparam int unsigned FI_SVC  = 0;
   localparam int unsigned FI_OVER = 1;
   localparam int unsigned FI_UNDER = 2;

   localparam logic [DW-1:0] CTRL_WMASK = 32'hFF1F_FFFF;
   localparam logic [DW-1:0] CTRL_INIT  = 32'h4000_0000;

   function automatic logic [DW-1:0] apply_alias(alias_op_e op,
                                                 logic [DW-1:0] cur,
                                                 logic [DW-1:0] wd);
      logic [DW-1:0] r;
      case (op)
         OP_SET:    r = cur | wd;
         OP_CLEAR:  r = cur & ~wd;
         OP_TOGGLE: r = cur ^ wd;
         default:   r = wd;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/aud_bus_decode.sv
module aud_bus_decode
   import aud_regbank_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   output logic              hit,
   output reg_sel_e          sel,
   output alias_op_e         op,
   output logic [3:0]        wr_en
);

   localparam int unsigned N_REGS = 4;

   logic upper_zero;

   generate
      if (ADDR_W > 6) begin : g_upper
         assign upper_zero = ~|addr[ADDR_W-1:6];
      end else begin : g_exact
         assign upper_zero = 1'b1;
      end
   endgenerate

   assign hit = upper_zero & (addr[1:0] == 2'b00);
   assign sel = reg_sel_e'(addr[5:4]);
   assign op  = alias_op_e'(addr[3:2]);

   for (genvar i = 0; i < N_REGS; i++) begin : g_wen
      assign wr_en[i] = we & hit & (addr[5:4] == 2'(i));
   end

endmodule

// File: rtl/aud_sticky_flags.sv
module aud_sticky_flags #(
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         srst,
   input  logic [N-1:0] evt,
   input  logic         clr_wr,
   input  logic [N-1:0] clr_bits,
   output logic [N-1:0] flags
);

   for (genvar i = 0; i < N; i++) begin : g_flag
      logic flag_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flag_q <= 1'b0;
         else if (srst)
            flag_q <= 1'b0;
         else
            flag_q <= evt[i] | (flag_q & ~(clr_wr & clr_bits[i]));
      end

      assign flags[i] = flag_q;

      // R5: a set flag survives every cycle without a matching clear
      assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_q && !(clr_wr && clr_bits[i]) && !srst) |=> flag_q);

      // R6: an event always leaves the flag set, even under a clear
      assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (evt[i] && !srst) |=> flag_q);
   end

endmodule

// File: rtl/aud_regbank.sv
module aud_regbank
   import aud_regbank_pkg::*;
#(
   parameter int unsigned   ADDR_W    = 8,
   parameter logic [7:0]    VER_MAJOR = 8'h01,
   parameter logic [7:0]    VER_MINOR = 8'h03,
   parameter logic [15:0]   VER_STEP  = 16'h0042
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_we,
   output logic [31:0]       bus_rdata,
   input  logic              hw_present,
   input  logic              hw_busy,
   input  logic              hw_dma_req,
   input  logic              evt_underflow,
   input  logic              evt_overflow,
   input  logic              evt_service,
   output logic              irq_err,
   output logic              irq_svc,
   output logic              dma_req,
   output logic [31:0]       ctrl_o,
   output logic [31:0]       data_o
);

   localparam logic [DW-1:0] VER_WORD = {VER_MAJOR, VER_MINOR, VER_STEP};

   generate
      if (ADDR_W < 6) begin : g_bad_addr_narrow
         $error("aud_regbank: ADDR_W must cover the 0x00-0x3C window");
      end
      if (ADDR_W > 32) begin : g_bad_addr_wide
         $error("aud_regbank: ADDR_W wider than 32 is not supported");
      end
   endgenerate

   logic          hit;
   reg_sel_e      sel;
   alias_op_e     op;
   logic [3:0]    wr_en;

   aud_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr  (bus_addr),
      .we    (bus_we),
      .hit   (hit),
      .sel   (sel),
      .op    (op),
      .wr_en (wr_en)
   );

   logic [DW-1:0] ctrl_q, ctrl_d;
   logic [DW-1:0] data_q, data_d;
   logic          srst;

   assign srst = ctrl_q[CB_SRST];

   always_comb begin
      ctrl_d = ctrl_q;
      if (wr_en[SEL_CTRL])
         ctrl_d = apply_alias(op, ctrl_q, bus_wdata) & CTRL_WMASK;
      if (srst)
         ctrl_d = {ctrl_d[CB_SRST:CB_GATE], CTRL_INIT[CB_GATE-1:0]};
   end

   always_comb begin
      data_d = data_q;
      if (srst)
         data_d = '0;
      else if (wr_en[SEL_DATA])
         data_d = apply_alias(op, data_q, bus_wdata);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_INIT;
         data_q <= '0;
      end else begin
         ctrl_q <= ctrl_d;
         data_q <= data_d;
      end
   end

   logic [N_FLAGS-1:0] evt_vec;
   logic [N_FLAGS-1:0] flags;
   logic               stat_clr;

   assign evt_vec[FI_SVC]   = evt_service;
   assign evt_vec[FI_OVER]  = evt_overflow;
   assign evt_vec[FI_UNDER] = evt_underflow;
   assign stat_clr = wr_en[SEL_STAT] & (op == OP_CLEAR);

   aud_sticky_flags #(.N(N_FLAGS)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .srst     (srst),
      .evt      (evt_vec),
      .clr_wr   (stat_clr),
      .clr_bits (bus_wdata[SB_FLAG_LO +: N_FLAGS]),
      .flags    (flags)
   );

   logic [DW-1:0] stat_word;

   always_comb begin
      stat_word = '0;
      stat_word[SB_PRESENT] = hw_present;
      stat_word[SB_DMA]     = hw_dma_req;
      stat_word[SB_FLAG_LO +: N_FLAGS] = flags;
      stat_word[SB_BUSY]    = hw_busy;
   end

   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         case (sel)
            SEL_CTRL: bus_rdata = ctrl_q;
            SEL_STAT: bus_rdata = stat_word;
            SEL_DATA: bus_rdata = data_q;
            default:  bus_rdata = VER_WORD;
         endcase
      end
   end

   assign irq_err = (flags[FI_UNDER] | flags[FI_OVER]) & ctrl_q[CB_ERR_EN];
   assign irq_svc = flags[FI_SVC] & ctrl_q[CB_SVC_EN];
   assign dma_req = hw_dma_req & ctrl_q[CB_RUN];
   assign ctrl_o  = ctrl_q;
   assign data_o  = data_q;

   // R3: reserved control bits never hold a one
   assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q & ~CTRL_WMASK) == '0);

   // R8: a write anywhere in the version window leaves the writable state alone
   assert_ver_write_no_effect_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && hit && sel == SEL_VER && !srst) |=> ($stable(ctrl_q) && $stable(data_q)));

   // R9: soft reset holds everything but its own two bits at default
   assert_srst_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (data_q == '0 && flags == '0 && ctrl_q[CB_GATE-1:0] == '0));

endmodule

// File: tb/aud_regbank_test.sv
`timescale 1ns/1ps
module aud_regbank_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_rdata;
   logic        hw_present = 1'b1;
   logic        hw_busy = 1'b0;
   logic        hw_dma_req = 1'b0;
   logic        evt_underflow = 1'b0;
   logic        evt_overflow = 1'b0;
   logic        evt_service = 1'b0;
   logic        irq_err, irq_svc, dma_req;
   logic [31:0] ctrl_o, data_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   aud_regbank uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .hw_present(hw_present),
      .hw_busy(hw_busy), .hw_dma_req(hw_dma_req), .evt_underflow(evt_underflow),
      .evt_overflow(evt_overflow), .evt_service(evt_service), .irq_err(irq_err),
      .irq_svc(irq_svc), .dma_req(dma_req), .ctrl_o(ctrl_o), .data_o(data_o)
   );

   // {write addr, write data, read addr, expected read}
   localparam int NV = 12;
   localparam logic [79:0] VEC [NV] = '{
      {8'h00, 32'h0000_00F1, 8'h00, 32'h0000_00F1},  // R2 plain write
      {8'h04, 32'h0300_0000, 8'h00, 32'h0300_00F1},  // R2 set
      {8'h08, 32'h0000_0070, 8'h00, 32'h0300_0081},  // R2 clear
      {8'h0C, 32'h0100_0003, 8'h00, 32'h0200_0082},  // R2 toggle
      {8'h00, 32'h00E0_0000, 8'h00, 32'h0000_0000},  // R3 reserved bits
      {8'h20, 32'h1234_ABCD, 8'h24, 32'h1234_ABCD},  // R1 alias read
      {8'h2C, 32'hFFFF_0000, 8'h28, 32'hEDCB_ABCD},  // R2 toggle data
      {8'h24, 32'h0000_0032, 8'h2C, 32'hEDCB_ABFF},  // R2 set data
      {8'h28, 32'hED00_00FF, 8'h20, 32'h00CB_AB00},  // R2 clear data
      {8'h30, 32'hFFFF_FFFF, 8'h3C, 32'h0103_0042},  // R8 version
      {8'h40, 32'hFFFF_FFFF, 8'h40, 32'h0000_0000},  // R1 out of window
      {8'h01, 32'hFFFF_FFFF, 8'h04, 32'h0000_0000}   // R1 misaligned
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      check(req, bus_rdata, exp);
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: evt_underflow = 1'b1;
         1: evt_overflow  = 1'b1;
         default: evt_service = 1'b1;
      endcase
      @(negedge clk);
      evt_underflow = 1'b0; evt_overflow = 1'b0; evt_service = 1'b0;
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 / R4 / R10 reset state
      rd_chk("R3 ctrl reset", 8'h00, 32'h4000_0000);
      rd_chk("R4 status reset", 8'h10, 32'h8000_0000);
      check("R10 data_o reset", data_o, 32'h0);
      check("R7 irq_err reset", {31'b0, irq_err}, 32'h0);

      // vector walk
      for (int i = 0; i < NV; i++) begin
         wr(VEC[i][79:72], VEC[i][71:40]);
         rd_chk($sformatf("vector %0d (R1/R2/R3/R8)", i), VEC[i][39:32], VEC[i][31:0]);
      end

      // R4 live mirrors, writes ignored
      @(negedge clk);
      hw_busy = 1'b1; hw_dma_req = 1'b1;
      rd_chk("R4 mirrors", 8'h10, 32'h8001_0001);
      wr(8'h14, 32'hFFFF_FFFF);
      wr(8'h10, 32'hFFFF_FFFF);
      hw_present = 1'b0; hw_busy = 1'b0; hw_dma_req = 1'b0;
      rd_chk("R4 status writes ignored", 8'h10, 32'h0);

      // R5 sticky, only clear alias clears
      pulse(0);
      rd_chk("R5 underflow set", 8'h10, 32'h0000_0040);
      wr(8'h10, 32'h0);
      wr(8'h14, 32'h70);
      wr(8'h1C, 32'h70);
      rd_chk("R5 plain/set/toggle no effect", 8'h10, 32'h0000_0040);
      wr(8'h18, 32'h20);
      rd_chk("R5 clear other bit", 8'h10, 32'h0000_0040);
      wr(8'h18, 32'h40);
      rd_chk("R5 cleared", 8'h10, 32'h0);

      // R7 interrupts and DMA gating
      @(negedge clk);
      hw_dma_req = 1'b1;
      #1 check("R7 dma gated off", {31'b0, dma_req}, 32'h0);
      wr(8'h04, 32'h0000_0001);
      #1 check("R7 dma with run", {31'b0, dma_req}, 32'h1);
      wr(8'h04, 32'h0200_0000);
      pulse(1);
      #1 check("R7 irq_err", {30'b0, irq_err, irq_svc}, 32'h2);
      wr(8'h18, 32'h20);
      #1 check("R7 irq_err cleared", {31'b0, irq_err}, 32'h0);
      pulse(2);
      rd_chk("R5 service flag", 8'h10, 32'h0001_0010);
      check("R7 irq_svc disabled", {31'b0, irq_svc}, 32'h0);
      wr(8'h04, 32'h0100_0000);
      #1 check("R7 irq_svc enabled", {31'b0, irq_svc}, 32'h1);
      wr(8'h18, 32'h10);
      #1 check("R7 irq_svc cleared", {31'b0, irq_svc}, 32'h0);
      @(negedge clk);
      hw_dma_req = 1'b0;

      // R6 event beats simultaneous clear
      @(negedge clk);
      evt_overflow = 1'b1; bus_addr = 8'h18; bus_wdata = 32'h20; bus_we = 1'b1;
      @(negedge clk);
      evt_overflow = 1'b0; bus_we = 1'b0;
      rd_chk("R6 event wins", 8'h10, 32'h0000_0020);
      check("R6 irq_err held", {31'b0, irq_err}, 32'h1);
      wr(8'h18, 32'h20);
      check("R10 ctrl_o", ctrl_o, 32'h0300_0001);

      // R9 soft reset
      wr(8'h20, 32'hCAFE_0001);
      pulse(0);
      wr(8'h04, 32'h8000_0000);
      @(negedge clk);
      rd_chk("R9 ctrl held", 8'h00, 32'h8000_0000);
      rd_chk("R9 data cleared", 8'h20, 32'h0);
      rd_chk("R9 flags cleared", 8'h10, 32'h0);
      check("R9 irq_err cleared", {31'b0, irq_err}, 32'h0);
      wr(8'h20, 32'h0000_0055);
      rd_chk("R9 data write ignored", 8'h20, 32'h0);
      wr(8'h04, 32'h4000_0000);
      check("R9 gate writable", ctrl_o, 32'hC000_0000);
      pulse(0);
      rd_chk("R9 event ignored", 8'h10, 32'h0);
      wr(8'h08, 32'h8000_0000);
      rd_chk("R9 released", 8'h00, 32'h4000_0000);
      wr(8'h20, 32'h0000_0077);
      rd_chk("R9 data after release", 8'h20, 32'h0000_0077);
      check("R10 data_o", data_o, 32'h0000_0077);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule